// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the address of each access in a four-beat burst. In any cycle the caller either starts a burst or continues one. To start a burst it drives the advance input low, and the presented address becomes the starting address. To continue it drives advance high, and the block moves to the next beat. Only the two lowest address bits take part in the sequence. The upper bits keep the value captured at the last load.

Two orderings are available, chosen by a mode input that stays fixed for a whole session:

- **Linear:** the beat number is added to the starting low bits, modulo four.
- **Interleaved:** the starting low bits are XORed with the beat number.

After four addresses the sequence returns to the starting address. The address and the beat index are both registered. The result of the control presented before an edge appears after that edge.

Top module: `burst_agen`

## Requirements
- R1: After reset, the address output is all zeros and the beat index is 0.
- R2: A clock edge with advance low captures the whole input address. After that edge the address output equals it and the beat index is 0, regardless of the ordering mode.
- R3: A clock edge with advance high increments the 2-bit beat index modulo 4 (3 goes to 0).
- R4: With the mode input low (linear), the low two address bits equal the start's low two bits plus the beat index, modulo 4. For example, start 2 gives 2, 3, 0, 1.
- R5: With the mode input high (interleaved), the low two address bits equal the start's low two bits XOR the beat index. For example, start 1 gives 1, 0, 3, 2.
- R6: After the fourth consecutive advance following a load, the address output is again the loaded start address.
- R7: While advance is high, the address input is ignored and the upper address bits keep the value loaded last.
- R8: Advances with no load since reset sequence from the start address zero.
- R9: A load in the middle of a burst abandons that burst and restarts at beat 0 from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| advance | input | 1 | 0 loads a new start address, 1 steps to the next beat |
| orderInterleave | input | 1 | Ordering mode, held static: 0 linear, 1 interleaved |
| loadAddr | input | ADDR_W | Start address, sampled when advance is low |
| curAddr | output | ADDR_W | Address of the current access |
| beatIdx | output | 2 | Beat number within the burst, 0 to 3 |

## Verification
The bench builds the block with a 6-bit address. This small width lets it load every possible start address in both ordering modes. After each load it advances five times, which covers every start/beat pair, the wrap on the fourth advance, and the step after the wrap. Each load that follows those five advances arrives with the beat index at 1, so every load is also a mid-burst restart. During each advance the bench drives the inverse of the start address on the address input. This shows that the input is ignored and that the upper bits are held.

// File: rtl/burst_agen_pkg.sv
package burst_agen_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic loadStart;
    logic stepBeat;
  } agenStrobe_t;
endpackage

// File: rtl/agen_ctrl.sv
module agen_ctrl
  import burst_agen_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  output agenStrobe_t       strobe,
  output logic [BEAT_W-1:0] beatIdx
);
  logic [BEAT_W-1:0] beatQ;

  always_comb begin
    strobe.loadStart = ~advance;
    strobe.stepBeat  = advance;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 beatQ <= '0;
    else if (strobe.loadStart) beatQ <= '0;
    else                       beatQ <= beatQ + 1'b1;
  end

  assign beatIdx = beatQ;

  p_load_clears_beat_r2: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> beatIdx == '0);

  p_step_wraps_beat_r3: assert property (@(posedge clk) disable iff (!rstN)
    advance |=> beatIdx == BEAT_W'($past(beatIdx) + 1'b1));
endmodule

// File: rtl/agen_dpath.sv
module agen_dpath
  import burst_agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  agenStrobe_t       strobe,
  input  logic              orderInterleave,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [BEAT_W-1:0] beatIdx,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] startQ;
  logic [BEAT_W-1:0] lowLin;
  logic [BEAT_W-1:0] lowIlv;
  logic [BEAT_W-1:0] lowSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 startQ <= '0;
    else if (strobe.loadStart) startQ <= loadAddr;
  end

  always_comb begin
    lowLin = startQ[BEAT_W-1:0] + beatIdx;
    lowIlv = startQ[BEAT_W-1:0] ^ beatIdx;
    lowSel = orderInterleave ? lowIlv : lowLin;
  end

  generate
    if (HI_W > 0) begin : g_hi
      assign curAddr = {startQ[ADDR_W-1:BEAT_W], lowSel};
    end else begin : g_low_only
      assign curAddr = lowSel;
    end
  endgenerate

  p_load_captures_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadStart |=> curAddr == $past(loadAddr));

  p_upper_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepBeat |=> curAddr[ADDR_W-1:BEAT_W] == $past(curAddr[ADDR_W-1:BEAT_W]));

  p_wrap_to_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepBeat && beatIdx == '1) |=> curAddr == startQ);
endmodule

// File: rtl/burst_agen.sv
module burst_agen
  import burst_agen_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BURST_LEN = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         advance,
  input  logic                         orderInterleave,
  input  logic [ADDR_W-1:0]            loadAddr,
  output logic [ADDR_W-1:0]            curAddr,
  output logic [$clog2(BURST_LEN)-1:0] beatIdx
);
  localparam int BEAT_W = $clog2(BURST_LEN);

  agenStrobe_t strobe;

  agen_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .advance(advance),
    .strobe(strobe), .beatIdx(beatIdx)
  );

  agen_dpath #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .orderInterleave(orderInterleave), .loadAddr(loadAddr),
    .beatIdx(beatIdx), .curAddr(curAddr)
  );
endmodule

// File: tb/burst_agen_bench.sv
module burst_agen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          advance = 1'b0;
  logic          orderInterleave = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic [AW-1:0] curAddr;
  logic [1:0]    beatIdx;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  burst_agen #(.ADDR_W(AW), .BURST_LEN(4)) u_burst_agen (
    .clk(clk), .rstN(rstN), .advance(advance),
    .orderInterleave(orderInterleave), .loadAddr(loadAddr),
    .curAddr(curAddr), .beatIdx(beatIdx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at negedge, let the posedge happen, sample a quarter period later
  task automatic step(input logic adv, input logic [AW-1:0] a);
    @(negedge clk);
    advance  = adv;
    loadAddr = a;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  function automatic int expLow(input int s, input int b, input bit ilv);
    return ilv ? ((s ^ b) & 3) : ((s + b) % 4);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 addr", int'(curAddr), 0);
    check("R1 beat", int'(beatIdx), 0);
    @(negedge clk);
    rstN = 1'b1;
    // R8: advance with no prior load steps from zero (linear)
    for (int k = 1; k <= 3; k++) begin
      step(1'b1, 6'h2A);
      check("R8 addr", int'(curAddr), k);
      check("R3 beat", int'(beatIdx), k);
    end
    for (int m = 0; m < 2; m++) begin
      orderInterleave = m[0];
      for (int s = 0; s < 64; s++) begin
        // beat is nonzero here (R9): load must restart
        step(1'b0, AW'(s));
        check("R2/R9 addr", int'(curAddr), s);
        check("R2/R9 beat", int'(beatIdx), 0);
        for (int k = 1; k <= 5; k++) begin
          step(1'b1, ~AW'(s));
          check("R3 beat", int'(beatIdx), k % 4);
          check("R7 upper", int'(curAddr) >> 2, s >> 2);
          if (m == 0) check("R4 low", int'(curAddr) & 3, expLow(s, k % 4, 1'b0));
          else        check("R5 low", int'(curAddr) & 3, expLow(s, k % 4, 1'b1));
          if (k == 4) check("R6 wrap", int'(curAddr), s);
        end
      end
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule